// File: doc/BRIEF.md
# Burst Write Data Feeder with Hidden Memory Latency

This block sits between a 4 KB on-chip buffer and a bus-master engine that performs write bursts. When told to start, it raises a request toward the engine. The engine answers with a one-cycle attribute strobe. In that cycle the feeder drives the transfer attribute word onto its output bus. In the same cycle it issues the read of word 0 from the buffer.

The buffer has a registered read port with one cycle of latency. Starting the first read on the attribute strobe puts word 0 on the output bus before the engine's first data-advance pulse arrives. Every later advance pulse samples the word currently shown and triggers the read of the following address. The engine may therefore pulse back to back, or leave any number of idle cycles between pulses.

A block holds 4096 bytes / (word width / 8) words. The feeder never reads past the last word of the block. It reports completion with a one-cycle done pulse and then returns to idle.

Top module: `burst_feeder`

## Requirements
- R1: After reset, req_o, done_o and ram_rd_o are all 0.
- R2: A go_i pulse in idle raises req_o in the next cycle. req_o then stays high until the cycle in which attr_vld_i is seen.
- R3: In the cycle where attr_vld_i is high while req_o is high, dout_o equals attr_i, ram_rd_o is 1 and ram_addr_o is 0. In the next cycle req_o is 0 and dout_o already shows buffer word 0.
- R4: At the k-th data_nxt_i pulse of a transfer (k counted from 1), dout_o equals buffer word k-1. This holds for back-to-back pulses and for any gap between pulses.
- R5: Each data_nxt_i pulse other than the final one issues exactly one read, ram_rd_o = 1, at the next ascending address. Word k then appears on dout_o in the cycle after the pulse.
- R6: The final pulse, number DEPTH, issues no read. A transfer issues exactly DEPTH reads in total, at addresses 0 to DEPTH-1.
- R7: done_o is 1 for exactly the one cycle after the final pulse, and the feeder is idle afterwards. The next transfer starts again at address 0.
- R8: data_nxt_i and attr_vld_i are ignored while idle. They cause no read, and dout_o keeps showing the buffer's output register rather than attr_i.
- R9: Between data_nxt_i pulses no read is issued and dout_o holds the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Start one block transfer (honoured when idle) |
| attr_i | input | WORD_W | Transfer attribute word to present |
| req_o | output | 1 | Request toward the bus engine |
| attr_vld_i | input | 1 | Engine strobe: attribute cycle |
| data_nxt_i | input | 1 | Engine strobe: current word taken, next word due next cycle |
| dout_o | output | WORD_W | Attribute word or buffer data |
| ram_rd_o | output | 1 | Buffer read enable |
| ram_addr_o | output | AW | Buffer word address |
| ram_rdata_i | input | WORD_W | Buffer registered read data |
| done_o | output | 1 | One-cycle pulse after the final word |

## Verification
The bench builds the feeder with WORD_W = 16 and BLOCK_BYTES = 32, which gives a block of 16 words. With a block that short, the final-word boundary, the suppressed last read and the restart at address 0 are all reached several times within a few hundred cycles. Transfers run with purely back-to-back advance pulses and with random gaps. Each transfer uses a fresh buffer pattern and a fresh attribute word, so a stale or shifted word is detected.

// File: rtl/burst_feeder_pkg.sv
package burst_feeder_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2
    } feed_st_e;
endpackage

// File: rtl/burst_feeder_ctr.sv
module burst_feeder_ctr #(
    parameter int LIMIT = 1024,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [CW-1:0] cnt_o,
    output logic          full_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_s;

    ctr_s ctr_d, ctr_q;

    assign full_o = (ctr_q.cnt == CW'(LIMIT));
    assign cnt_o  = ctr_q.cnt;

    always_comb begin
        ctr_d = ctr_q;
        if (clr_i) begin
            ctr_d.cnt = '0;
        end else if (inc_i && !full_o) begin
            ctr_d.cnt = ctr_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    // R5: an accepted increment moves the count by exactly one
    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && !full_o) |=> (cnt_o == $past(cnt_o) + CW'(1)));

    // R9: without increment or clear the count holds
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/burst_feeder_mux.sv
module burst_feeder_mux #(
    parameter int WORD_W = 32
) (
    input  logic              sel_attr_i,
    input  logic [WORD_W-1:0] attr_i,
    input  logic [WORD_W-1:0] mem_i,
    output logic [WORD_W-1:0] dout_o
);
    always_comb begin
        dout_o = sel_attr_i ? attr_i : mem_i;
    end
endmodule

// File: rtl/burst_feeder.sv
module burst_feeder
    import burst_feeder_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int BLOCK_BYTES = 4096,
    localparam int DEPTH = BLOCK_BYTES / (WORD_W / 8),
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [WORD_W-1:0] attr_i,
    output logic              req_o,
    input  logic              attr_vld_i,
    input  logic              data_nxt_i,
    output logic [WORD_W-1:0] dout_o,
    output logic              ram_rd_o,
    output logic [AW-1:0]     ram_addr_o,
    input  logic [WORD_W-1:0] ram_rdata_i,
    output logic              done_o
);
    typedef struct packed {
        feed_st_e st;
        logic     done;
    } feed_s;

    feed_s feed_d, feed_q;

    logic          rd_inc, tk_inc, cnt_clr, sel_attr;
    logic [CW-1:0] rd_cnt, tk_cnt;
    logic          rd_full, tk_full;

    always_comb begin
        feed_d      = feed_q;
        feed_d.done = 1'b0;
        rd_inc      = 1'b0;
        tk_inc      = 1'b0;
        cnt_clr     = 1'b0;
        sel_attr    = 1'b0;
        unique case (feed_q.st)
            ST_IDLE: begin
                if (go_i) feed_d.st = ST_REQ;
            end
            ST_REQ: begin
                if (attr_vld_i) begin
                    sel_attr  = 1'b1;
                    rd_inc    = 1'b1;
                    feed_d.st = ST_XFER;
                end
            end
            ST_XFER: begin
                if (data_nxt_i) begin
                    tk_inc = 1'b1;
                    if (!rd_full) rd_inc = 1'b1;
                    if (tk_cnt == CW'(DEPTH - 1)) begin
                        feed_d.st   = ST_IDLE;
                        feed_d.done = 1'b1;
                        cnt_clr     = 1'b1;
                    end
                end
            end
            default: feed_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            feed_q.st   <= ST_IDLE;
            feed_q.done <= 1'b0;
        end else begin
            feed_q <= feed_d;
        end
    end

    burst_feeder_ctr #(.LIMIT(DEPTH)) u_rd_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cnt_clr),
        .inc_i  (rd_inc),
        .cnt_o  (rd_cnt),
        .full_o (rd_full)
    );

    burst_feeder_ctr #(.LIMIT(DEPTH)) u_tk_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cnt_clr),
        .inc_i  (tk_inc),
        .cnt_o  (tk_cnt),
        .full_o (tk_full)
    );

    burst_feeder_mux #(.WORD_W(WORD_W)) u_mux (
        .sel_attr_i (sel_attr),
        .attr_i     (attr_i),
        .mem_i      (ram_rdata_i),
        .dout_o     (dout_o)
    );

    assign req_o      = (feed_q.st == ST_REQ);
    assign done_o     = feed_q.done;
    assign ram_rd_o   = rd_inc;
    assign ram_addr_o = rd_cnt[AW-1:0];

    // R2: request holds until the attribute strobe arrives
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !attr_vld_i) |=> req_o);

    // R3: first read of the block starts in the attribute cycle at address 0
    p_first_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && attr_vld_i) |-> (ram_rd_o && ram_addr_o == '0));

    // R6: the take counter never passes the block size
    p_no_overtake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tk_full);

    // R6: once all reads are issued, no further read is requested
    p_no_overread_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_full |-> !ram_rd_o);

    // R7: done is a single-cycle pulse and the feeder is idle after it
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !req_o));

    // R8: idle feeder shows the buffer register and issues no read
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (feed_q.st == ST_IDLE) |-> (!ram_rd_o && dout_o == ram_rdata_i));
endmodule

// File: tb/burst_feeder_test.sv
`timescale 1ns/1ps
module burst_feeder_test;
    localparam int WORD_W      = 16;
    localparam int BLOCK_BYTES = 32;
    localparam int DEPTH       = BLOCK_BYTES / (WORD_W / 8);
    localparam int AW          = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              go_i = 1'b0;
    logic [WORD_W-1:0] attr_i = '0;
    logic              req_o;
    logic              attr_vld_i = 1'b0;
    logic              data_nxt_i = 1'b0;
    logic [WORD_W-1:0] dout_o;
    logic              ram_rd_o;
    logic [AW-1:0]     ram_addr_o;
    logic [WORD_W-1:0] ram_rdata = '0;
    logic              done_o;

    logic [WORD_W-1:0] mem [DEPTH];

    int checks = 0;
    int fails  = 0;
    int seed   = 0;
    int reads  = 0;
    logic [WORD_W-1:0] last_word;

    always #2.5 clk = ~clk;

    burst_feeder #(.WORD_W(WORD_W), .BLOCK_BYTES(BLOCK_BYTES)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (go_i),
        .attr_i      (attr_i),
        .req_o       (req_o),
        .attr_vld_i  (attr_vld_i),
        .data_nxt_i  (data_nxt_i),
        .dout_o      (dout_o),
        .ram_rd_o    (ram_rd_o),
        .ram_addr_o  (ram_addr_o),
        .ram_rdata_i (ram_rdata),
        .done_o      (done_o)
    );

    // buffer model: registered read port, output holds between reads
    always_ff @(posedge clk) begin
        if (ram_rd_o) ram_rdata <= mem[ram_addr_o];
    end

    function automatic logic [WORD_W-1:0] pattern(int idx, int t);
        return WORD_W'(idx * 37 + t * 911 + 16'h5a00) ^ WORD_W'(t << 3);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic run_xfer(int t, int gapmax);
        logic [WORD_W-1:0] attr_w;
        for (int i = 0; i < DEPTH; i++) mem[i] = pattern(i, t);
        attr_w = WORD_W'($urandom);
        attr_i = attr_w;
        reads  = 0;
        tick(); go_i = 1'b1;
        @(negedge clk); chk(req_o == 1'b0, "R2 req registered", req_o, 0);
        tick(); go_i = 1'b0;
        @(negedge clk); chk(req_o == 1'b1, "R2 req raised", req_o, 1);
        for (int w = 0; w < int'($urandom % 4); w++) begin
            tick();
            @(negedge clk); chk(req_o == 1'b1, "R2 req held", req_o, 1);
        end
        tick(); attr_vld_i = 1'b1;
        @(negedge clk);
        chk(dout_o == attr_w, "R3 attr on bus", dout_o, attr_w);
        chk(ram_rd_o == 1'b1 && ram_addr_o == '0, "R3 first read addr0", ram_addr_o, 0);
        if (ram_rd_o) reads++;
        tick(); attr_vld_i = 1'b0;
        @(negedge clk);
        chk(req_o == 1'b0, "R3 req dropped", req_o, 0);
        chk(dout_o == mem[0], "R3 word0 prefetched", dout_o, mem[0]);
        for (int k = 0; k < DEPTH; k++) begin
            int gaps;
            gaps = (gapmax > 0) ? int'($urandom % (gapmax + 1)) : 0;
            for (int g = 0; g < gaps; g++) begin
                tick();
                @(negedge clk);
                chk(dout_o == mem[k], "R9 word held in gap", dout_o, mem[k]);
                chk(ram_rd_o == 1'b0, "R9 no read in gap", ram_rd_o, 0);
            end
            tick(); data_nxt_i = 1'b1;
            @(negedge clk);
            chk(dout_o == mem[k], "R4 word at pulse", dout_o, mem[k]);
            if (k < DEPTH - 1) begin
                chk(ram_rd_o == 1'b1 && ram_addr_o == AW'(k + 1), "R5 next read",
                    ram_addr_o, k + 1);
            end else begin
                chk(ram_rd_o == 1'b0, "R6 no read on last", ram_rd_o, 0);
            end
            if (ram_rd_o) reads++;
            tick(); data_nxt_i = 1'b0;
            @(negedge clk);
            if (k < DEPTH - 1) begin
                chk(dout_o == mem[k + 1], "R5 next word ready", dout_o, mem[k + 1]);
                chk(done_o == 1'b0, "R7 no early done", done_o, 0);
            end else begin
                chk(done_o == 1'b1, "R7 done pulse", done_o, 1);
            end
        end
        chk(reads == DEPTH, "R6 read total", reads, DEPTH);
        tick();
        @(negedge clk);
        chk(done_o == 1'b0, "R7 done one cycle", done_o, 1'b0);
        chk(req_o == 1'b0, "R7 idle after", req_o, 0);
        last_word = mem[DEPTH - 1];
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        chk(req_o == 1'b0 && done_o == 1'b0 && ram_rd_o == 1'b0, "R1 reset outputs",
            {req_o, done_o, ram_rd_o}, 0);
        tick(); rst_n = 1'b1;
        @(negedge clk);
        chk(req_o == 1'b0 && done_o == 1'b0 && ram_rd_o == 1'b0, "R1 after release",
            {req_o, done_o, ram_rd_o}, 0);

        run_xfer(1, 0);
        run_xfer(2, 3);

        // R8: strobes while idle are ignored
        tick(); data_nxt_i = 1'b1; attr_vld_i = 1'b1; attr_i = ~last_word;
        @(negedge clk);
        chk(ram_rd_o == 1'b0, "R8 no read when idle", ram_rd_o, 0);
        chk(dout_o == last_word, "R8 attr not shown idle", dout_o, last_word);
        chk(req_o == 1'b0, "R8 stays idle", req_o, 0);
        tick(); data_nxt_i = 1'b0; attr_vld_i = 1'b0;
        @(negedge clk);
        chk(req_o == 1'b0 && done_o == 1'b0, "R8 still idle", {req_o, done_o}, 0);
        chk(dout_o == last_word, "R8 register kept", dout_o, last_word);

        run_xfer(3, 5);
        run_xfer(4, 1);
        finish_run();
    end
endmodule